// File: doc/BRIEF.md
# Receive Acceptance Filter with Masked Group Boxes

This block chooses the message box that takes an incoming CAN frame. At the end of each received frame, the receive engine gives it the identifier, the format (standard 11-bit or extended 29-bit) and the frame type (data or remote). The block compares that frame against the settings of up to sixteen boxes. Only boxes numbered from zero up to a programmed upper limit take part. A box must also be set up for reception, and its format and frame type must match the frame's.

Two group functions can each be pointed at any one box by its number. A group box compares only the identifier bits that its mask leaves clear. When a group box accepts a frame, the block raises a request so that the box's stored identifier is replaced by the identifier that was actually received. When several boxes match, the lowest-numbered box is chosen. The decision is taken in the cycle of the frame-end strobe and presented on registers one cycle later.

Top module: `can_accept_filter`

## Requirements
- R1: After synchronous reset, `result_valid`, `hit` and `id_load` are 0 and `hit_box` is 0.
- R2: `result_valid` is high only in the cycle after a cycle with `frame_end` high. The decision uses the inputs present during the strobe cycle. `hit` and `hit_box` hold their values until the next strobe.
- R3: A box whose number is greater than `last_box` is never selected.
- R4: A box matches only when its format bit `box_ext[b]` equals `rx_ext` (1 = extended). For a standard frame only identifier bits 28..18 are compared, and a difference in bits 17..0 does not prevent a match.
- R5: A box matches only when its frame-type bit `box_remote[b]` equals `rx_remote` (1 = remote frame).
- R6: A box with `box_tx[b]` = 1 (transmit box) is never selected.
- R7: A box that is not a group box matches only when every compared identifier bit equals the received identifier.
- R8: Group g (0 or 1) is active when `grp_en[g]` is 1. It then applies to the box numbered `grp_box_flat[4g+3:4g]`. In that box the identifier bits whose mask bit in `grp_mask_flat[29g+28:29g]` is 1 are ignored. When `grp_en[g]` is 0, the box uses the exact comparison.
- R9: When several boxes match, `hit_box` is the smallest matching box number.
- R10: `id_load` pulses together with `result_valid` only when the selected box is an active group box. `id_load_value` is then `rx_id` for an extended frame, and `{rx_id[28:18], 18'b0}` for a standard frame.
- R11: When both active groups name the same box, the mask of group 0 is used.
- R12: When no box matches, `hit`, `hit_box` and `id_load` are 0 in the result cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | One-cycle strobe: a received frame is complete |
| rx_id | input | 29 | Received identifier; a standard ID occupies bits 28..18 |
| rx_ext | input | 1 | Received format, 1 = extended |
| rx_remote | input | 1 | Received frame type, 1 = remote |
| last_box | input | 4 | Highest box number taking part |
| box_id_flat | input | 464 | Box b identifier at bits [29b+28:29b] |
| box_ext | input | 16 | Per-box format bit |
| box_remote | input | 16 | Per-box frame-type bit |
| box_tx | input | 16 | Per-box transmit flag, 1 = excluded from reception |
| grp_en | input | 2 | Group function enables |
| grp_box_flat | input | 8 | Group g box number at bits [4g+3:4g] |
| grp_mask_flat | input | 58 | Group g mask at bits [29g+28:29g], 1 = ignore bit |
| result_valid | output | 1 | Decision presented this cycle |
| hit | output | 1 | A box accepted the frame |
| hit_box | output | 4 | Number of the accepting box |
| id_load | output | 1 | Request to overwrite the group box identifier |
| id_load_value | output | 29 | Identifier to store on `id_load` |

## Verification
The bench targets the lowest-box rule with two matching boxes. A design that scans from the top would pick box 7 instead of box 2. It also covers standard frames whose low 18 identifier bits differ; a filter that compared all 29 bits would miss these. The group tests use a masked box that hits only through its mask, a disabled group that has to fall back to the exact comparison, and two groups that name the same box, where giving the wrong group priority flips hit and miss. The range limit, transmit exclusion and format or type mismatches each present a box that would otherwise match, so a missing guard shows up as a false hit.

// File: rtl/can_accept_pkg.sv
`timescale 1ns/1ps
package can_accept_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  // Identifier bits that take part in the comparison for a given format.
  function automatic logic [ID_W-1:0] fmt_care(input logic ext);
    if (ext) return '1;
    return {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};
  endfunction

  // Identifier value stored into a group box on acceptance.
  function automatic logic [ID_W-1:0] stored_id(input logic [ID_W-1:0] id,
                                                input logic ext);
    return id & fmt_care(ext);
  endfunction
endpackage

// File: rtl/can_box_match.sv
`timescale 1ns/1ps
module can_box_match
  import can_accept_pkg::*;
(
  input  logic [ID_W-1:0] rx_id,
  input  logic            rx_ext,
  input  logic            rx_remote,
  input  logic [ID_W-1:0] box_id,
  input  logic            box_ext,
  input  logic            box_remote,
  input  logic            box_tx,
  input  logic            in_range,
  input  logic [ID_W-1:0] ign_mask,
  output logic            match
);
  logic [ID_W-1:0] care;
  logic            id_eq;

  always_comb begin
    care  = fmt_care(rx_ext) & ~ign_mask;
    id_eq = ((rx_id ^ box_id) & care) == '0;
    match = in_range && !box_tx && (box_ext == rx_ext) &&
            (box_remote == rx_remote) && id_eq;
  end
endmodule

// File: rtl/can_lowest_pick.sv
`timescale 1ns/1ps
module can_lowest_pick #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end

  // R9: the chosen request is set and no lower one is
  p_lowest_r9: assert property (@(posedge clk) disable iff (rst)
    found |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));
  p_none_r12: assert property (@(posedge clk) disable iff (rst)
    !found |-> (req == '0));
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter
  import can_accept_pkg::*;
#(
  parameter int NBOX = 16,
  parameter int NGRP = 2,
  localparam int BOXW = $clog2(NBOX)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_end,
  input  logic [ID_W-1:0]      rx_id,
  input  logic                 rx_ext,
  input  logic                 rx_remote,
  input  logic [BOXW-1:0]      last_box,
  input  logic [NBOX*ID_W-1:0] box_id_flat,
  input  logic [NBOX-1:0]      box_ext,
  input  logic [NBOX-1:0]      box_remote,
  input  logic [NBOX-1:0]      box_tx,
  input  logic [NGRP-1:0]      grp_en,
  input  logic [NGRP*BOXW-1:0] grp_box_flat,
  input  logic [NGRP*ID_W-1:0] grp_mask_flat,
  output logic                 result_valid,
  output logic                 hit,
  output logic [BOXW-1:0]      hit_box,
  output logic                 id_load,
  output logic [ID_W-1:0]      id_load_value
);
  logic [NBOX-1:0] is_grp;
  logic [ID_W-1:0] ign_mask [NBOX];
  logic [NBOX-1:0] match;
  logic            any_hit;
  logic [BOXW-1:0] pick_idx;

  for (genvar b = 0; b < NBOX; b++) begin : g_box
    // Group resolution; lower group index overrides (R11)
    always_comb begin
      is_grp[b]   = 1'b0;
      ign_mask[b] = '0;
      for (int g = NGRP - 1; g >= 0; g--) begin
        if (grp_en[g] && (grp_box_flat[g*BOXW +: BOXW] == BOXW'(b))) begin
          is_grp[b]   = 1'b1;
          ign_mask[b] = grp_mask_flat[g*ID_W +: ID_W];
        end
      end
    end

    can_box_match u_match (
      .rx_id      (rx_id),
      .rx_ext     (rx_ext),
      .rx_remote  (rx_remote),
      .box_id     (box_id_flat[b*ID_W +: ID_W]),
      .box_ext    (box_ext[b]),
      .box_remote (box_remote[b]),
      .box_tx     (box_tx[b]),
      .in_range   (BOXW'(b) <= last_box),
      .ign_mask   (ign_mask[b]),
      .match      (match[b])
    );
  end

  can_lowest_pick #(.N(NBOX)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .req   (match),
    .found (any_hit),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_valid  <= 1'b0;
      hit           <= 1'b0;
      hit_box       <= '0;
      id_load       <= 1'b0;
      id_load_value <= '0;
    end else begin
      result_valid <= frame_end;
      id_load      <= frame_end && any_hit && is_grp[pick_idx];
      if (frame_end) begin
        hit           <= any_hit;
        hit_box       <= pick_idx;
        id_load_value <= stored_id(rx_id, rx_ext);
      end
    end
  end

  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_end && any_hit) |-> (pick_idx <= last_box));
  p_tx_excluded_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_end && any_hit) |-> !box_tx[pick_idx]);
  p_valid_r2: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> result_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> (!result_valid && $stable(hit) && $stable(hit_box)));
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    id_load |-> (result_valid && hit));
endmodule

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/1ps
module tb_can_accept_filter;
  localparam int NB = 16;
  localparam int IW = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_end = 1'b0;
  logic [IW-1:0] rx_id = '0;
  logic rx_ext = 1'b0, rx_remote = 1'b0;
  logic [3:0] last_box = 4'hF;
  logic [IW-1:0] b_id [NB];
  logic [NB*IW-1:0] box_id_flat;
  logic [NB-1:0] box_ext, box_remote, box_tx;
  logic [1:0] grp_en;
  logic [3:0] gbox [2];
  logic [IW-1:0] gmask [2];
  logic [7:0] grp_box_flat;
  logic [57:0] grp_mask_flat;
  logic result_valid, hit, id_load;
  logic [3:0] hit_box;
  logic [IW-1:0] id_load_value;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < NB; i++) begin : g_pack
    assign box_id_flat[i*IW +: IW] = b_id[i];
  end
  assign grp_box_flat  = {gbox[1], gbox[0]};
  assign grp_mask_flat = {gmask[1], gmask[0]};

  can_accept_filter dut (
    .clk(clk), .rst(rst), .frame_end(frame_end), .rx_id(rx_id),
    .rx_ext(rx_ext), .rx_remote(rx_remote), .last_box(last_box),
    .box_id_flat(box_id_flat), .box_ext(box_ext), .box_remote(box_remote),
    .box_tx(box_tx), .grp_en(grp_en), .grp_box_flat(grp_box_flat),
    .grp_mask_flat(grp_mask_flat), .result_valid(result_valid), .hit(hit),
    .hit_box(hit_box), .id_load(id_load), .id_load_value(id_load_value)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NB; i++) b_id[i] = '0;
    box_ext = '0; box_remote = '0; box_tx = '1;
    grp_en = '0; gbox[0] = '0; gbox[1] = '0; gmask[0] = '0; gmask[1] = '0;
    last_box = 4'hF; rx_remote = 1'b0;
  endtask

  // strobe one frame; returns at the negedge after the capturing edge
  task automatic fire();
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic h, input logic [3:0] bx,
                            input logic ld, input logic [IW-1:0] val);
    chk({tag, " valid"}, 32'(result_valid), 32'(1'b1));
    chk({tag, " hit"}, 32'(hit), 32'(h));
    if (h) chk({tag, " box"}, 32'(hit_box), 32'(bx));
    else   chk({tag, " box"}, 32'(hit_box), 32'h0);
    chk({tag, " load"}, 32'(id_load), 32'(ld));
    if (ld) chk({tag, " value"}, 32'(id_load_value), 32'(val));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", 32'(result_valid), 0);
    chk("R1 hit", 32'(hit), 0);
    chk("R1 box", 32'(hit_box), 0);
    chk("R1 load", 32'(id_load), 0);
  endtask

  task automatic t_exact();
    clear_cfg();
    b_id[5] = 29'h1ABCDE12; box_ext[5] = 1; box_tx[5] = 0;
    rx_id = 29'h1ABCDE12; rx_ext = 1;
    fire(); expect_res("R7 exact ext", 1, 5, 0, '0);
    rx_id = 29'h1ABCDE13;
    fire(); expect_res("R7/R12 one bit off", 0, 0, 0, '0);
  endtask

  task automatic t_timing();
    clear_cfg();
    b_id[2] = 29'h00000777; box_ext[2] = 1; box_tx[2] = 0;
    rx_id = 29'h00000777; rx_ext = 1;
    @(negedge clk) frame_end = 1'b1;
    #1 chk("R2 not before edge", 32'(result_valid), 0);
    @(negedge clk) frame_end = 1'b0;
    rx_id = 29'h00000000;
    chk("R2 valid after strobe", 32'(result_valid), 1);
    chk("R2 box", 32'(hit_box), 2);
    @(negedge clk);
    chk("R2 pulse ends", 32'(result_valid), 0);
    chk("R2 hit held", 32'(hit), 1);
    chk("R2 box held", 32'(hit_box), 2);
  endtask

  task automatic t_standard();
    clear_cfg();
    b_id[3] = {11'h5A3, 18'h00000}; box_ext[3] = 0; box_tx[3] = 0;
    rx_id = {11'h5A3, 18'h3FFFF}; rx_ext = 0;
    fire(); expect_res("R4 std low bits ignored", 1, 3, 0, '0);
    rx_ext = 1;
    fire(); expect_res("R4 format mismatch", 0, 0, 0, '0);
    rx_ext = 0; rx_remote = 1;
    fire(); expect_res("R5 type mismatch", 0, 0, 0, '0);
    box_remote[3] = 1;
    fire(); expect_res("R5 remote match", 1, 3, 0, '0);
    box_tx[3] = 1;
    fire(); expect_res("R6 tx box excluded", 0, 0, 0, '0);
  endtask

  task automatic t_range();
    clear_cfg();
    b_id[9] = 29'h0ABCDEF0; box_ext[9] = 1; box_tx[9] = 0;
    rx_id = 29'h0ABCDEF0; rx_ext = 1; last_box = 4'd8;
    fire(); expect_res("R3 above limit", 0, 0, 0, '0);
    last_box = 4'd9;
    fire(); expect_res("R3 at limit", 1, 9, 0, '0);
  endtask

  task automatic t_priority();
    clear_cfg();
    b_id[2] = 29'h15555555; box_ext[2] = 1; box_tx[2] = 0;
    b_id[7] = 29'h15555555; box_ext[7] = 1; box_tx[7] = 0;
    rx_id = 29'h15555555; rx_ext = 1;
    fire(); expect_res("R9 lowest wins", 1, 2, 0, '0);
  endtask

  task automatic t_group();
    clear_cfg();
    b_id[4] = 29'h12345600; box_ext[4] = 1; box_tx[4] = 0;
    grp_en = 2'b01; gbox[0] = 4'd4; gmask[0] = 29'h000000FF;
    rx_id = 29'h123456AB; rx_ext = 1;
    fire(); expect_res("R8/R10 masked ext hit", 1, 4, 1, 29'h123456AB);
    rx_id = 29'h123457AB;
    fire(); expect_res("R8 unmasked bit differs", 0, 0, 0, '0);
    rx_id = 29'h123456AB; grp_en = 2'b00;
    fire(); expect_res("R8 disabled group exact", 0, 0, 0, '0);
    // standard-format group box, mask covers bit 18
    grp_en = 2'b10; gbox[1] = 4'd4; gmask[1] = 29'h00040000;
    b_id[4] = {11'h700, 18'h0}; box_ext[4] = 0;
    rx_id = {11'h701, 18'h00155}; rx_ext = 0;
    fire(); expect_res("R10 std group load", 1, 4, 1, {11'h701, 18'h0});
    // a lower plain box also matches: it wins, no load
    b_id[1] = {11'h701, 18'h0}; box_tx[1] = 0;
    fire(); expect_res("R9/R10 plain lower box", 1, 1, 0, '0);
  endtask

  task automatic t_shared();
    clear_cfg();
    b_id[6] = 29'h00000000; box_ext[6] = 1; box_tx[6] = 0;
    grp_en = 2'b11; gbox[0] = 4'd6; gbox[1] = 4'd6;
    gmask[0] = '0; gmask[1] = '1;
    rx_id = 29'h1F0F0F0F; rx_ext = 1;
    fire(); expect_res("R11 group0 exact mask", 0, 0, 0, '0);
    gmask[0] = '1; gmask[1] = '0;
    fire(); expect_res("R11 group0 full mask", 1, 6, 1, 29'h1F0F0F0F);
  endtask

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_exact();
    t_timing();
    t_standard();
    t_range();
    t_priority();
    t_group();
    t_shared();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule